// File: doc/BRIEF.md
# Seconds Counter with Snapshot Read

A free-running 48-bit seconds counter for an always-on timekeeping block. A one-cycle enable from a slow oscillator domain (nominally 32.768 kHz) feeds a prescaler of `DIV_W` bits. The counter advances by one each time that prescaler wraps. Software sees the count as two 32-bit words on a simple word-indexed register bus. The upper word carries only 16 live bits. Writing either word loads a new time and restarts the prescaler.

Because the two words cannot be read together, a freeze mode is provided. When it is selected, a read of the low word captures the upper 16 bits. Later reads of the upper word return that captured value until one of them releases the hold. Software must therefore always read the low word first. The snapshot logic is a two-state machine:
- `SNAP_LIVE`: the upper word reads the running count. A low-word read in freeze mode takes the transition *capture* to `SNAP_HELD`.
- `SNAP_HELD`: the upper word reads the captured value. A further low-word read *recaptures* and stays in this state. An upper-word read, or leaving freeze mode, takes the transition *release* back to `SNAP_LIVE`.

A 48-bit alarm pair, split like the counter, is compared against the count. Two event sources feed a sticky raw status: the alarm match and an external alternate event input. Per-source enables are changed through separate write-one-to-set and write-one-to-clear registers. The active-high level interrupt is the OR of raw status ANDed with the enables.

Top module: `rtc_seconds_core`

Register word index on `bus_addr_i`:
- 0: time low
- 1: time high
- 2: control
- 3: alarm low
- 4: alarm high
- 5: raw status
- 6: masked status
- 7: enable set
- 8: enable clear

Any other index reads 0.

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The count rises by exactly one for every 2^DIV_W cycles in which `tick_i` is high. With `tick_i` low the count holds.
- R3: A write to word 0 loads count bits 31:0, and a write to word 1 loads bits 47:32 from write bits 15:0. Either write restarts the prescaler from zero. Write bits 31:16 of word 1 (and of word 4) are dropped, and those bits read as 0.
- R4: The control word's bits 25:24 select the freeze mode, and the value 2 means snapshot. In snapshot mode a read of word 0 captures count bits 47:32. Reads of word 1 then return the captured value until the first read of word 1, which releases the hold.
- R5: With any other freeze-mode value, word 1 reads the live count.
- R6: Alarm words 3 and 4 split the target the same way as the counter. Raw status bit 0 is set one cycle after the count becomes equal to the alarm, whether through a tick or through a load. It stays set until software clears it, and it is not set again while the count remains equal.
- R7: A high cycle on `alt_evt_i` sets raw status bit 1.
- R8: Word 6 reads raw status ANDed with the enables. Writing 1 to a bit of word 6 clears that raw bit, and writing 0 leaves it unchanged.
- R9: Writing 1 to bit 0 or bit 1 of word 7 sets that enable, and writing 1 to the same bit of word 8 clears it. Zero bits have no effect. Reading word 7 or word 8 returns the current enables.
- R10: `irq_o` is high exactly when some raw status bit and its enable are both 1.
- R11: Word 5 returns raw status regardless of the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow-oscillator enable, one cycle per oscillator period |
| alt_evt_i | input | 1 | Alternate event, sets raw status bit 1 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (read side effects apply at the clock edge) |
| bus_addr_i | input | ADDR_W | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
On every cycle, the assertions check several properties:
- the count moves only on a prescaler wrap or a load;
- raw alarm status never drops without a clearing write;
- a held snapshot never changes until a recapture;
- a clearing write to the enable takes effect;
- the interrupt never rises while all enables are off;
- upper-word reads keep their reserved bits at zero.

The exact tick count per second and the reset of the prescaler on a load can only be shown by the bench's scenarios. The same holds for the captured-versus-live value when a carry crosses into the upper word between the two reads, and for the edge-only nature of the alarm match while the count rests on the target.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BUS_W = 32;
    localparam int LO_W  = 32;

    localparam int RA_TIME_LO  = 0;
    localparam int RA_TIME_HI  = 1;
    localparam int RA_CTRL     = 2;
    localparam int RA_ALARM_LO = 3;
    localparam int RA_ALARM_HI = 4;
    localparam int RA_STAT_RAW = 5;
    localparam int RA_STAT     = 6;
    localparam int RA_EN_SET   = 7;
    localparam int RA_EN_CLR   = 8;

    localparam int FMODE_LSB = 24;
    localparam logic [1:0] FMODE_SNAPSHOT = 2'd2;

    typedef enum logic {
        SNAP_LIVE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic sec_pulse_o
);

    logic [DIV_W-1:0] div_q;
    logic             at_top;

    assign at_top      = &div_q;
    assign sec_pulse_o = tick_i && at_top && !clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr_i) begin
            div_q <= '0;
        end else if (tick_i) begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int CNT_W = 48,
    parameter int LO_W  = 32,
    localparam int HI_W = CNT_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             ld_lo_i,
    input  logic             ld_hi_i,
    input  logic [LO_W-1:0]  lo_val_i,
    input  logic [HI_W-1:0]  hi_val_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_lo_i || ld_hi_i) begin
            if (ld_lo_i) cnt_q[LO_W-1:0]     <= lo_val_i;
            if (ld_hi_i) cnt_q[CNT_W-1:LO_W] <= hi_val_i;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/rtc_snapshot_fsm.sv
module rtc_snapshot_fsm
    import rtc_pkg::*;
#(
    parameter int HI_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            snap_en_i,
    input  logic            lo_rd_i,
    input  logic            hi_rd_i,
    input  logic [HI_W-1:0] live_hi_i,
    output logic [HI_W-1:0] hi_view_o,
    output logic [HI_W-1:0] snap_o,
    output snap_state_t     state_o
);

    snap_state_t     state_q, state_d;
    logic [HI_W-1:0] snap_q;
    logic            capture;

    assign capture = snap_en_i && lo_rd_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_LIVE: if (capture) state_d = SNAP_HELD;
            SNAP_HELD: begin
                if (capture)                     state_d = SNAP_HELD;
                else if (!snap_en_i || hi_rd_i)  state_d = SNAP_LIVE;
            end
            default: state_d = SNAP_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SNAP_LIVE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) snap_q <= live_hi_i;
        end
    end

    always_comb begin
        unique case (state_q)
            SNAP_HELD: hi_view_o = snap_q;
            default:   hi_view_o = live_hi_i;
        endcase
    end

    assign snap_o  = snap_q;
    assign state_o = state_q;

endmodule

// File: rtl/rtc_event_irq.sv
module rtc_event_irq #(
    parameter int CNT_W = 48,
    parameter int NSRC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] alarm_i,
    input  logic             alt_evt_i,
    input  logic [NSRC-1:0]  stat_clr_i,
    input  logic [NSRC-1:0]  en_set_i,
    input  logic [NSRC-1:0]  en_clr_i,
    output logic [NSRC-1:0]  raw_o,
    output logic [NSRC-1:0]  en_o,
    output logic             irq_o
);

    logic            match, match_q;
    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] raw_q, en_q;

    assign match = (cnt_i == alarm_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= 1'b1;
        else        match_q <= match;
    end

    always_comb begin
        evt    = '0;
        evt[0] = match && !match_q;
        if (NSRC > 1) evt[NSRC-1] = alt_evt_i;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                raw_q[s] <= 1'b0;
                en_q[s]  <= 1'b0;
            end else begin
                if (evt[s])             raw_q[s] <= 1'b1;
                else if (stat_clr_i[s]) raw_q[s] <= 1'b0;
                if (en_set_i[s])        en_q[s]  <= 1'b1;
                else if (en_clr_i[s])   en_q[s]  <= 1'b0;
            end
        end
    end

    assign raw_o = raw_q;
    assign en_o  = en_q;
    assign irq_o = |(raw_q & en_q);

endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
    import rtc_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int CNT_W  = 48,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              alt_evt_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              irq_o
);

    localparam int HI_W = CNT_W - LO_W;
    localparam int NSRC = 2;
    localparam int PAD_W = BUS_W - HI_W;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
        return a == ADDR_W'(idx);
    endfunction

    logic wr_lo, wr_hi, wr_ctrl, wr_alo, wr_ahi, stat_wr, en_set_wr, en_clr_wr;
    logic lo_rd, hi_rd, ld_any, sec_pulse;

    assign wr_lo     = bus_wr_i && hit(bus_addr_i, RA_TIME_LO);
    assign wr_hi     = bus_wr_i && hit(bus_addr_i, RA_TIME_HI);
    assign wr_ctrl   = bus_wr_i && hit(bus_addr_i, RA_CTRL);
    assign wr_alo    = bus_wr_i && hit(bus_addr_i, RA_ALARM_LO);
    assign wr_ahi    = bus_wr_i && hit(bus_addr_i, RA_ALARM_HI);
    assign stat_wr   = bus_wr_i && hit(bus_addr_i, RA_STAT);
    assign en_set_wr = bus_wr_i && hit(bus_addr_i, RA_EN_SET);
    assign en_clr_wr = bus_wr_i && hit(bus_addr_i, RA_EN_CLR);
    assign lo_rd     = bus_rd_i && hit(bus_addr_i, RA_TIME_LO);
    assign hi_rd     = bus_rd_i && hit(bus_addr_i, RA_TIME_HI);
    assign ld_any    = wr_lo || wr_hi;

    logic [1:0]       fmode_q;
    logic [CNT_W-1:0] alarm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmode_q <= '0;
            alarm_q <= '0;
        end else begin
            if (wr_ctrl) fmode_q <= bus_wdata_i[FMODE_LSB +: 2];
            if (wr_alo)  alarm_q[LO_W-1:0]     <= bus_wdata_i[LO_W-1:0];
            if (wr_ahi)  alarm_q[CNT_W-1:LO_W] <= bus_wdata_i[HI_W-1:0];
        end
    end

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .clr_i       (ld_any),
        .sec_pulse_o (sec_pulse)
    );

    logic [CNT_W-1:0] cnt;

    rtc_sec_counter #(.CNT_W(CNT_W), .LO_W(LO_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (sec_pulse),
        .ld_lo_i  (wr_lo),
        .ld_hi_i  (wr_hi),
        .lo_val_i (bus_wdata_i[LO_W-1:0]),
        .hi_val_i (bus_wdata_i[HI_W-1:0]),
        .cnt_o    (cnt)
    );

    logic [HI_W-1:0] hi_view, snap_val;
    snap_state_t     snap_state;

    rtc_snapshot_fsm #(.HI_W(HI_W)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_en_i (fmode_q == FMODE_SNAPSHOT),
        .lo_rd_i   (lo_rd),
        .hi_rd_i   (hi_rd),
        .live_hi_i (cnt[CNT_W-1:LO_W]),
        .hi_view_o (hi_view),
        .snap_o    (snap_val),
        .state_o   (snap_state)
    );

    logic [NSRC-1:0] raw, en;

    rtc_event_irq #(.CNT_W(CNT_W), .NSRC(NSRC)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt),
        .alarm_i    (alarm_q),
        .alt_evt_i  (alt_evt_i),
        .stat_clr_i (stat_wr   ? bus_wdata_i[NSRC-1:0] : '0),
        .en_set_i   (en_set_wr ? bus_wdata_i[NSRC-1:0] : '0),
        .en_clr_i   (en_clr_wr ? bus_wdata_i[NSRC-1:0] : '0),
        .raw_o      (raw),
        .en_o       (en),
        .irq_o      (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            case (int'(bus_addr_i))
                RA_TIME_LO:  bus_rdata_o = cnt[LO_W-1:0];
                RA_TIME_HI:  bus_rdata_o = {{PAD_W{1'b0}}, hi_view};
                RA_CTRL:     bus_rdata_o = BUS_W'(fmode_q) << FMODE_LSB;
                RA_ALARM_LO: bus_rdata_o = alarm_q[LO_W-1:0];
                RA_ALARM_HI: bus_rdata_o = {{PAD_W{1'b0}}, alarm_q[CNT_W-1:LO_W]};
                RA_STAT_RAW: bus_rdata_o = BUS_W'(raw);
                RA_STAT:     bus_rdata_o = BUS_W'(raw & en);
                RA_EN_SET,
                RA_EN_CLR:   bus_rdata_o = BUS_W'(en);
                default:     bus_rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk
    import rtc_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int HI_W   = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              ld_any,
    input logic              sec_pulse,
    input logic [CNT_W-1:0]  cnt,
    input logic [1:0]        raw,
    input logic [1:0]        en,
    input logic              stat_wr,
    input logic              en_clr_wr,
    input logic [31:0]       bus_wdata_i,
    input logic              bus_rd_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_rdata_o,
    input logic              lo_rd,
    input snap_state_t       snap_state,
    input logic [HI_W-1:0]   snap_val,
    input logic              irq_o
);

    // R2: count moves only on a prescaler wrap or a load
    p_count_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sec_pulse) && !$past(ld_any)) |-> $stable(cnt));

    // R2: no tick means no increment
    p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick_i) && !$past(ld_any)) |-> $stable(cnt));

    // R6: raw alarm bit is sticky until a clearing write
    p_raw_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw[0]) && !($past(stat_wr) && $past(bus_wdata_i[0]))) |-> raw[0]);

    // R4: held snapshot value does not change without a recapture
    p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_state == SNAP_HELD && $past(snap_state) == SNAP_HELD && !$past(lo_rd))
            |-> $stable(snap_val));

    // R9: a clear write on enable bit 0 takes effect
    p_en_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_clr_wr) && $past(bus_wdata_i[0])) |-> !en[0]);

    // R10: interrupt never active with all enables off
    p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en != 2'b00));

    // R3: upper-word reads keep reserved bits at zero
    p_hi_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == ADDR_W'(RA_TIME_HI)) |-> ((bus_rdata_o >> HI_W) == 32'd0));

endmodule

bind rtc_seconds_core rtc_seconds_chk #(
    .CNT_W  (CNT_W),
    .HI_W   (HI_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .ld_any      (ld_any),
    .sec_pulse   (sec_pulse),
    .cnt         (cnt),
    .raw         (raw),
    .en          (en),
    .stat_wr     (stat_wr),
    .en_clr_wr   (en_clr_wr),
    .bus_wdata_i (bus_wdata_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .lo_rd       (lo_rd),
    .snap_state  (snap_state),
    .snap_val    (snap_val),
    .irq_o       (irq_o)
);

// File: tb/test_rtc_seconds_core.sv
module test_rtc_seconds_core;

    localparam int DIV_W = 4;
    localparam int SEC   = 1 << DIV_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        alt = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_seconds_core #(.DIV_W(DIV_W), .CNT_W(48), .ADDR_W(4)) i_rtc_seconds_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .alt_evt_i   (alt),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = 4'(a); wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = 4'(a);
        #1 d = rdata;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int r = 0; r < 9; r++) begin
            rd_reg(r, d);
            chk("R1 register after reset", d, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_count;
        logic [31:0] d;
        wr_reg(1, 32'h0);
        wr_reg(0, 32'h100);
        ticks(3 * SEC);
        rd_reg(0, d);
        chk("R2 three seconds of ticks", d, 32'h103);
        idle(40);
        rd_reg(0, d);
        chk("R2 no tick holds count", d, 32'h103);
        ticks(SEC - 1);
        rd_reg(0, d);
        chk("R2 one tick short of a second", d, 32'h103);
        ticks(1);
        rd_reg(0, d);
        chk("R2 last tick of the second", d, 32'h104);
    endtask

    task automatic t_prescale_clear;
        logic [31:0] d;
        wr_reg(0, 32'h200);
        ticks(10);
        wr_reg(0, 32'h300);
        ticks(10);
        rd_reg(0, d);
        chk("R3 load restarts prescaler", d, 32'h300);
        ticks(SEC - 10);
        rd_reg(0, d);
        chk("R3 full second after load", d, 32'h301);
    endtask

    task automatic t_hi_reserved;
        logic [31:0] d;
        wr_reg(1, 32'hABCD_1234);
        rd_reg(1, d);
        chk("R3 time high reserved bits dropped", d, 32'h0000_1234);
        wr_reg(4, 32'hFFFF_0007);
        rd_reg(4, d);
        chk("R3 alarm high reserved bits dropped", d, 32'h0000_0007);
        wr_reg(3, 32'h0000_0055);
        rd_reg(3, d);
        chk("R6 alarm low word", d, 32'h0000_0055);
    endtask

    task automatic t_snapshot;
        logic [31:0] d;
        wr_reg(2, 32'h0200_0000);
        rd_reg(2, d);
        chk("R4 control freeze field", d, 32'h0200_0000);
        wr_reg(0, 32'hFFFF_FFFF);
        wr_reg(1, 32'h5);
        rd_reg(0, d);
        chk("R4 low word before carry", d, 32'hFFFF_FFFF);
        ticks(SEC);
        rd_reg(1, d);
        chk("R4 high word frozen across carry", d, 32'h5);
        rd_reg(1, d);
        chk("R4 second high read released", d, 32'h6);
        rd_reg(0, d);
        chk("R4 low word after carry", d, 32'h0);
    endtask

    task automatic t_live;
        logic [31:0] d;
        wr_reg(2, 32'h0100_0000);
        wr_reg(0, 32'hFFFF_FFFF);
        wr_reg(1, 32'h9);
        rd_reg(0, d);
        ticks(SEC);
        rd_reg(1, d);
        chk("R5 other mode reads live high", d, 32'hA);
        wr_reg(2, 32'h0);
    endtask

    task automatic t_alarm;
        logic [31:0] d;
        wr_reg(8, 32'h3);
        wr_reg(6, 32'h3);
        wr_reg(3, 32'h12);
        wr_reg(4, 32'h1);
        wr_reg(1, 32'h1);
        wr_reg(0, 32'h10);
        idle(2);
        wr_reg(6, 32'h3);
        ticks(SEC);
        idle(2);
        rd_reg(5, d);
        chk("R6 no match before target", d, 32'h0);
        ticks(SEC);
        idle(2);
        rd_reg(5, d);
        chk("R11 raw shows alarm while disabled", d, 32'h1);
        rd_reg(6, d);
        chk("R8 masked status disabled", d, 32'h0);
        chk("R10 irq low while disabled", {31'b0, irq}, 32'h0);
        wr_reg(7, 32'h1);
        chk("R10 irq after enable", {31'b0, irq}, 32'h1);
        rd_reg(7, d);
        chk("R9 enable set readback", d, 32'h1);
        rd_reg(6, d);
        chk("R8 masked status enabled", d, 32'h1);
        wr_reg(6, 32'h2);
        rd_reg(5, d);
        chk("R8 zero bit leaves alarm status", d, 32'h1);
        wr_reg(6, 32'h1);
        idle(3);
        rd_reg(5, d);
        chk("R6 cleared and not re-set while equal", d, 32'h0);
        chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
        wr_reg(0, 32'h11);
        wr_reg(0, 32'h12);
        idle(2);
        rd_reg(5, d);
        chk("R6 load onto target sets status", d, 32'h1);
        wr_reg(8, 32'h2);
        rd_reg(7, d);
        chk("R9 clear of other bit no effect", d, 32'h1);
        wr_reg(8, 32'h1);
        rd_reg(8, d);
        chk("R9 enable clear readback", d, 32'h0);
        chk("R10 irq low after disable", {31'b0, irq}, 32'h0);
        rd_reg(5, d);
        chk("R11 raw kept after disable", d, 32'h1);
        wr_reg(6, 32'h1);
    endtask

    task automatic t_alt;
        logic [31:0] d;
        @(negedge clk);
        alt = 1'b1;
        @(posedge clk); #1;
        alt = 1'b0;
        idle(2);
        rd_reg(5, d);
        chk("R7 alternate event raw", d, 32'h2);
        chk("R10 irq low alt disabled", {31'b0, irq}, 32'h0);
        wr_reg(7, 32'h2);
        chk("R10 irq on alt enable", {31'b0, irq}, 32'h1);
        rd_reg(6, d);
        chk("R8 masked alt status", d, 32'h2);
        wr_reg(6, 32'h2);
        rd_reg(5, d);
        chk("R8 alt status cleared", d, 32'h0);
        chk("R10 irq after alt clear", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_count();
        t_prescale_clear();
        t_hi_reserved();
        t_snapshot();
        t_live();
        t_alarm();
        t_alt();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule